// File: doc/BRIEF.md
# Privilege-Masked Tag Control Register

This block holds the 64-bit control word that enables and masks the tag propagation and tag check units of a processor pipeline. After reset the word is zero, so every tag function starts disabled. Software reaches the one physical register through three CSR addresses, one for each privilege mode. All three views read the same value. A write through the machine view replaces the whole word. A write through the supervisor or user view changes only the bits picked out by a write-enable mask for that mode.

Two further CSRs hold those write-enable masks. Only machine mode may access them, and both reset to all ones. The block takes CSR accesses from the pipeline: an address, an operation (read, write, set or clear), write data and the current privilege. It returns read data in the same cycle and applies the update at the next clock edge. An access to one of its addresses from a mode below the privilege field of that address (address bits [9:8]) sets an illegal flag and changes nothing. Raising the trap is left to the pipeline.

Top module: `tagcfg_csr`

## Requirements
- R1: After reset the control word `tag_ctrl` is 0, and both write-enable masks read as all ones.
- R2: Addresses 0xBF0, 0x9F0 and 0x8F0 all return the current control word. Addresses 0x7F0 and 0x7F1 return the user and supervisor write-enable masks. Read data is the value held before the access takes effect. `csr_hit` is 1 only for these five addresses, and any other address gives 0 read data and changes no state.
- R3: A legal write, set or clear through 0xBF0 gives the control word its computed value in every bit on the next clock edge.
- R4: A legal access through 0x8F0 changes only the control bits set in the user mask (0x7F0). Those bits take the computed value and all other bits keep their old value.
- R5: A legal access through 0x9F0 changes only the control bits set in the supervisor mask (0x7F1), in the same way.
- R6: The masks at 0x7F0 and 0x7F1 are read and written in full, and only from machine mode.
- R7: Privilege encoding is 0 = user, 1 = supervisor, 2 = reserved, 3 = machine. When `csr_req` is 1, the address is one of the five and its bits [9:8] exceed `priv`, `csr_illegal` is 1 in the same cycle, the read data is 0 and no register changes.
- R8: Operation codes are 0 = read, 1 = write, 2 = set, 3 = clear. Set computes old|wdata and clear computes old&~wdata. That computed value then passes through the same per-view mask merge as a plain write.
- R9: A read operation (code 0) changes no register, whatever the write data is.
- R10: While `csr_req` is 0, no register changes, `csr_illegal` is 0 and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| csr_req | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write, set or clear operand |
| priv | input | 2 | Current privilege mode |
| csr_rdata | output | 64 | Read data for the access, value before update |
| csr_hit | output | 1 | Address belongs to this block |
| csr_illegal | output | 1 | Access denied for privilege |
| tag_ctrl | output | 64 | Control word to the tag units |

## Verification
The hardest case to reach is a lower-privilege view that writes through a partial mask. It needs a machine-mode mask write, then a change of privilege, and only then a set or clear whose operand overlaps both masked and unmasked bits. The stimulus follows exactly that order with chosen patterns. It then runs a long random stream that mixes all five addresses, all four privilege values and all four operations, with a reference model in the bench tracking the masks. The random stream also covers mask values of zero and mask changes issued between two lower-privilege writes.

// File: rtl/tagcfg_pkg.sv
package tagcfg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_R = 2'b10,
    PRV_M = 2'b11
  } prv_e;

  localparam int NUM_EN_MASKS = 2;  // index 0 user, 1 supervisor
endpackage

// File: rtl/tagcfg_rst_sync.sv
module tagcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/tagcfg_decode.sv
module tagcfg_decode
  import tagcfg_pkg::*;
#(
  parameter int             AW         = 12,
  parameter logic [AW-1:0]  M_VIEW     = 12'hBF0,
  parameter logic [AW-1:0]  S_VIEW     = 12'h9F0,
  parameter logic [AW-1:0]  U_VIEW     = 12'h8F0,
  parameter logic [AW-1:0]  U_EN_ADDR  = 12'h7F0,
  parameter logic [AW-1:0]  S_EN_ADDR  = 12'h7F1
) (
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    priv,
  output logic          sel_m,
  output logic          sel_s,
  output logic          sel_u,
  output logic [NUM_EN_MASKS-1:0] sel_en,
  output logic          hit,
  output logic          illegal,
  output logic          wr_en
);
  logic [1:0] addr_prv;

  always_comb begin
    sel_m     = (addr == M_VIEW);
    sel_s     = (addr == S_VIEW);
    sel_u     = (addr == U_VIEW);
    sel_en[0] = (addr == U_EN_ADDR);
    sel_en[1] = (addr == S_EN_ADDR);
    hit       = sel_m | sel_s | sel_u | (|sel_en);
    addr_prv  = addr[9:8];
    illegal   = req & hit & (addr_prv > priv);
    wr_en     = req & hit & ~illegal & (csr_op_e'(op) != OP_READ);
  end
endmodule

// File: rtl/tagcfg_merge.sv
module tagcfg_merge
  import tagcfg_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] wmask,
  output logic [W-1:0] nxt
);
  logic [W-1:0] computed;

  always_comb begin
    unique case (csr_op_e'(op))
      OP_SET:   computed = cur | operand;
      OP_CLEAR: computed = cur & ~operand;
      default:  computed = operand;
    endcase
    nxt = (computed & wmask) | (cur & ~wmask);
  end
endmodule

// File: rtl/tagcfg_csr.sv
module tagcfg_csr
  import tagcfg_pkg::*;
#(
  parameter int            XLEN      = 64,
  parameter int            AW        = 12,
  parameter logic [AW-1:0] M_VIEW    = 12'hBF0,
  parameter logic [AW-1:0] S_VIEW    = 12'h9F0,
  parameter logic [AW-1:0] U_VIEW    = 12'h8F0,
  parameter logic [AW-1:0] U_EN_ADDR = 12'h7F0,
  parameter logic [AW-1:0] S_EN_ADDR = 12'h7F1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_req,
  input  logic [1:0]      csr_op,
  input  logic [AW-1:0]   csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [1:0]      priv,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  output logic            csr_illegal,
  output logic [XLEN-1:0] tag_ctrl
);
  localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

  logic rst_sync_n;
  logic sel_m, sel_s, sel_u, wr_en;
  logic [NUM_EN_MASKS-1:0] sel_en;

  logic [XLEN-1:0] ctrl_q, ctrl_d, ctrl_wmask;
  logic            ctrl_ce;
  logic [NUM_EN_MASKS-1:0][XLEN-1:0] en_q, en_d;
  logic [NUM_EN_MASKS-1:0]           en_ce;

  tagcfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  tagcfg_decode #(
    .AW(AW), .M_VIEW(M_VIEW), .S_VIEW(S_VIEW), .U_VIEW(U_VIEW),
    .U_EN_ADDR(U_EN_ADDR), .S_EN_ADDR(S_EN_ADDR)
  ) u_decode (
    .req     (csr_req),
    .op      (csr_op),
    .addr    (csr_addr),
    .priv    (priv),
    .sel_m   (sel_m),
    .sel_s   (sel_s),
    .sel_u   (sel_u),
    .sel_en  (sel_en),
    .hit     (csr_hit),
    .illegal (csr_illegal),
    .wr_en   (wr_en)
  );

  // Control word: the view picks the write-enable mask
  always_comb begin
    if (sel_m)      ctrl_wmask = ALL_ONES;
    else if (sel_s) ctrl_wmask = en_q[1];
    else            ctrl_wmask = en_q[0];
    ctrl_ce = wr_en & (sel_m | sel_s | sel_u);
  end

  tagcfg_merge #(.W(XLEN)) u_ctrl_merge (
    .op      (csr_op),
    .cur     (ctrl_q),
    .operand (csr_wdata),
    .wmask   (ctrl_wmask),
    .nxt     (ctrl_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  // Write-enable mask registers, machine-only, written in full
  for (genvar g = 0; g < NUM_EN_MASKS; g++) begin : g_en
    assign en_ce[g] = wr_en & sel_en[g];

    tagcfg_merge #(.W(XLEN)) u_en_merge (
      .op      (csr_op),
      .cur     (en_q[g]),
      .operand (csr_wdata),
      .wmask   (ALL_ONES),
      .nxt     (en_d[g])
    );

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    en_q[g] <= ALL_ONES;
      else if (en_ce[g])  en_q[g] <= en_d[g];
    end
  end

  // Read data: pre-update value, zero when not a legal hit
  always_comb begin
    csr_rdata = '0;
    if (csr_req && !csr_illegal) begin
      if (sel_m || sel_s || sel_u) csr_rdata = ctrl_q;
      else if (sel_en[0])          csr_rdata = en_q[0];
      else if (sel_en[1])          csr_rdata = en_q[1];
    end
  end

  assign tag_ctrl = ctrl_q;
endmodule

// File: rtl/tagcfg_csr_chk.sv
module tagcfg_csr_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_req,
  input logic [1:0]      csr_op,
  input logic [1:0]      priv,
  input logic            csr_hit,
  input logic            csr_illegal,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] ctrl,
  input logic [XLEN-1:0] uen,
  input logic [XLEN-1:0] sen,
  input logic            u_view,
  input logic            s_view
);
  // R7
  illegal_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_illegal) |=> ($stable(ctrl) && $stable(uen) && $stable(sen)));

  // R7
  illegal_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_hit && csr_req && csr_rdata == '0));

  // R10
  idle_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |=> ($stable(ctrl) && $stable(uen) && $stable(sen)));

  // R9
  read_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_op == 2'b00) |=> ($stable(ctrl) && $stable(uen) && $stable(sen)));

  // R4
  user_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && u_view) |=> (((ctrl ^ $past(ctrl)) & ~$past(uen)) == '0));

  // R5
  sup_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && s_view) |=> (((ctrl ^ $past(ctrl)) & ~$past(sen)) == '0));

  // R6
  mask_machine_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && priv != 2'b11) |=> ($stable(uen) && $stable(sen)));
endmodule

bind tagcfg_csr tagcfg_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .csr_req     (csr_req),
  .csr_op      (csr_op),
  .priv        (priv),
  .csr_hit     (csr_hit),
  .csr_illegal (csr_illegal),
  .csr_rdata   (csr_rdata),
  .ctrl        (ctrl_q),
  .uen         (en_q[0]),
  .sen         (en_q[1]),
  .u_view      (sel_u),
  .s_view      (sel_s)
);

// File: tb/tb_tagcfg_csr.sv
module tb_tagcfg_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_req;
  logic [1:0]  csr_op;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata;
  logic [1:0]  priv;
  logic [63:0] csr_rdata;
  logic        csr_hit;
  logic        csr_illegal;
  logic [63:0] tag_ctrl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  logic [63:0] m_ctrl, m_uen, m_sen;

  always #4 clk = ~clk;

  tagcfg_csr dut (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv(priv),
    .csr_rdata(csr_rdata), .csr_hit(csr_hit), .csr_illegal(csr_illegal),
    .tag_ctrl(tag_ctrl)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access per clock; compares combinational outputs, then registered state
  task automatic access(input bit rq, input logic [1:0] op, input logic [11:0] a,
                        input logic [63:0] wd, input logic [1:0] pv, input string req);
    bit hit, ill;
    logic [63:0] cur, msk, comp, exp_rd;
    int kind;
    @(negedge clk);
    csr_req = rq; csr_op = op; csr_addr = a; csr_wdata = wd; priv = pv;
    #2;
    kind = (a == 12'hBF0) ? 1 : (a == 12'h9F0) ? 2 : (a == 12'h8F0) ? 3 :
           (a == 12'h7F0) ? 4 : (a == 12'h7F1) ? 5 : 0;
    hit = (kind != 0);
    ill = rq && hit && (int'(a[9:8]) > int'(pv));
    cur = (kind == 4) ? m_uen : (kind == 5) ? m_sen : m_ctrl;
    exp_rd = (rq && hit && !ill) ? cur : 64'h0;
    chk(csr_hit == hit, {req, " hit"}, 64'(csr_hit), 64'(hit));
    chk(csr_illegal == ill, {req, " illegal"}, 64'(csr_illegal), 64'(ill));
    chk(csr_rdata == exp_rd, {req, " rdata"}, csr_rdata, exp_rd);
    if (rq && hit && !ill && op != 2'd0) begin
      msk = (kind == 2) ? m_sen : (kind == 3) ? m_uen : 64'hFFFF_FFFF_FFFF_FFFF;
      comp = (op == 2'd2) ? (cur | wd) : (op == 2'd3) ? (cur & ~wd) : wd;
      comp = (comp & msk) | (cur & ~msk);
      if (kind == 4) m_uen = comp;
      else if (kind == 5) m_sen = comp;
      else m_ctrl = comp;
    end
    @(posedge clk); #1;
    chk(tag_ctrl == m_ctrl, {req, " tag_ctrl"}, tag_ctrl, m_ctrl);
  endtask

  initial begin
    rst_n = 1'b0; csr_req = 1'b0; csr_op = 2'd0; csr_addr = '0; csr_wdata = '0; priv = 2'd3;
    m_ctrl = '0; m_uen = '1; m_sen = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    chk(tag_ctrl == 64'h0, "R1 reset ctrl", tag_ctrl, 64'h0);
    access(1, 2'd0, 12'h7F0, 64'h0, 2'd3, "R1 uen reset");
    access(1, 2'd0, 12'h7F1, 64'h0, 2'd3, "R1 sen reset");

    // R3 machine view write; R2 shadow reads
    access(1, 2'd1, 12'hBF0, 64'hDEAD_BEEF_0123_4567, 2'd3, "R3 machine write");
    access(1, 2'd0, 12'h9F0, 64'h0, 2'd1, "R2 sup view read");
    access(1, 2'd0, 12'h8F0, 64'h0, 2'd0, "R2 user view read");
    access(1, 2'd0, 12'hBF0, 64'h0, 2'd3, "R2 machine view read");
    access(1, 2'd1, 12'h300, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, "R2 unmapped");

    // R6 masks; R4 user merge
    access(1, 2'd1, 12'h7F0, 64'h0000_0000_0000_FFFF, 2'd3, "R6 uen write");
    access(1, 2'd1, 12'h8F0, 64'h1234_5678_9ABC_DEF0, 2'd0, "R4 user write");
    access(1, 2'd2, 12'h8F0, 64'hFFFF_0000_0000_000F, 2'd0, "R8 user set");
    access(1, 2'd3, 12'h8F0, 64'hFFFF_FFFF_FFFF_00F0, 2'd0, "R8 user clear");

    // R5 supervisor merge
    access(1, 2'd1, 12'h7F1, 64'hFF00_FF00_FF00_FF00, 2'd3, "R6 sen write");
    access(1, 2'd1, 12'h9F0, 64'h0, 2'd1, "R5 sup write");
    access(1, 2'd2, 12'h9F0, 64'h0F0F_F0F0_0F0F_F0F0, 2'd1, "R8 sup set");
    access(1, 2'd3, 12'hBF0, 64'h00FF_00FF_0000_FFFF, 2'd3, "R8 machine clear");

    // R9 read with data
    access(1, 2'd0, 12'hBF0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, "R9 read no effect");

    // R7 illegal accesses
    access(1, 2'd1, 12'hBF0, 64'hAAAA_AAAA_AAAA_AAAA, 2'd0, "R7 user to machine view");
    access(1, 2'd1, 12'h9F0, 64'hAAAA_AAAA_AAAA_AAAA, 2'd0, "R7 user to sup view");
    access(1, 2'd1, 12'h7F0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, "R7 user to uen");
    access(1, 2'd2, 12'h7F1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, "R7 sup to sen");
    access(1, 2'd1, 12'hBF0, 64'h5555_5555_5555_5555, 2'd2, "R7 reserved to machine");
    access(1, 2'd1, 12'h9F0, 64'h5555_5555_5555_5555, 2'd2, "R7 reserved to sup");
    access(1, 2'd0, 12'h7F0, 64'h0, 2'd3, "R6 uen kept");

    // R10 request low
    access(0, 2'd1, 12'hBF0, 64'h0, 2'd3, "R10 idle write");

    // R4 zero user mask
    access(1, 2'd1, 12'h7F0, 64'h0, 2'd3, "R6 uen zero");
    access(1, 2'd1, 12'h8F0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, "R4 zero mask write");

    // random mix, all requirements
    for (int i = 0; i < 2000; i++) begin
      logic [11:0] a;
      int sel;
      sel = int'($urandom_range(0, 5));
      a = (sel == 0) ? 12'hBF0 : (sel == 1) ? 12'h9F0 : (sel == 2) ? 12'h8F0 :
          (sel == 3) ? 12'h7F0 : (sel == 4) ? 12'h7F1 : 12'(($urandom_range(0, 4095)));
      access(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)), a,
             {$urandom, $urandom}, 2'($urandom_range(0, 3)), "R2 R4 R5 R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule